// File: doc/BRIEF.md
# Temporal Redundancy Sampling Checker

This block protects one critical signal against a short transient produced by the combinational logic upstream of it. When a valid strobe is accepted, the block captures the data at that clock edge. A configuration bit selects a delay of one or two cycles, and after that delay the block captures the same signal again. The two captures are then compared. If they match, the first capture is forwarded with a one-cycle valid. If they differ, valid is withheld, a one-cycle transient flag is raised, and a saturating event counter is incremented.

An optional vote mode handles a mismatch differently. A third capture is taken one cycle after the second, and a bitwise two-of-three majority of the three captures is forwarded with valid and a corrected marker. The source must keep the data stable for the whole sampling window, including the extra cycle when the vote is used. The block accepts a new strobe only when it is idle.

Top module: `trc_guard`

## Requirements
- R1: After reset, out_valid, out_corrected and transient_flag are 0, out_data is 0 and transient_count is 0.
- R2: In_valid is accepted at edge E0. The first sample is in_data at E0. dly_sel=0 takes the second sample at E0+1, and dly_sel=1 takes it at E0+2. Values on in_data at any other edge inside the window have no effect on the result.
- R3: If the two samples are equal, out_valid is 1 with out_data equal to the first sample for exactly one cycle, starting after edge E0+D+1 (D = 1 or 2). out_corrected is 0 and out_valid is 0 before that edge.
- R4: If the samples differ and vote_en=0, out_valid stays 0 and transient_flag is 1 for exactly the one cycle after edge E0+D+1.
- R5: If the samples differ and vote_en=1, transient_flag pulses after E0+D+1 and a third sample is taken at E0+D+1. After E0+D+2, out_valid and out_corrected are 1 for one cycle. Each bit of out_data is the value that at least two of the three samples share.
- R6: transient_count increments by one on each detected mismatch, updating at edge E0+D+1. It stops at its all-ones value.
- R7: cnt_clr=1 at an edge sets transient_count to 0. A clear wins over a mismatch counted at the same edge.
- R8: While a check is in progress, in_valid, dly_sel and vote_en are ignored. No extra result is produced, and the delay and vote mode latched at E0 stay in force.
- R9: When the samples agree, vote_en has no effect. Latency stays D+1 and out_corrected stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | DATA_W | Guarded signal |
| in_valid | input | 1 | Start a check; sampled only when idle |
| dly_sel | input | 1 | 0: second sample one cycle later, 1: two cycles later |
| vote_en | input | 1 | 1: take a third sample and vote on mismatch |
| cnt_clr | input | 1 | Synchronous clear of the event counter |
| out_data | output | DATA_W | Checked or voted data |
| out_valid | output | 1 | One-cycle qualifier for out_data |
| out_corrected | output | 1 | out_data came from the majority vote |
| transient_flag | output | 1 | One-cycle pulse on a detected mismatch |
| transient_count | output | CNT_W | Saturating count of mismatches |

## Verification
Take E0 as the accepting edge. The agree result and the flag are due after edge E0+D+1, the voted result after E0+D+2, and the counter moves at the same edge as the flag. The bench drives every input on the falling edge and steps through each transaction edge by edge. It samples at the falling edge after each due edge. It also checks that valid is still low one cycle earlier and low again one cycle later, which pins the latency exactly. Random transactions choose the delay, the vote mode and whether a second or third sample is corrupted. A bench function computes the expected data and count.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SECOND,
    ST_JUDGE,
    ST_ARB
  } trc_state_e;

  // State entered after the accepting edge: the hold state adds one cycle.
  function automatic trc_state_e state_after_accept(input logic long_delay);
    return long_delay ? ST_HOLD : ST_SECOND;
  endfunction

  // Two-of-three decision for a single bit, by population count.
  function automatic logic vote_bit(input logic a, input logic b, input logic c);
    logic [1:0] ones;
    ones = {1'b0, a} + {1'b0, b} + {1'b0, c};
    return ones >= 2'd2;
  endfunction

endpackage

// File: rtl/trc_capture.sv
module trc_capture
  import trc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              dly_sel,
  input  logic              vote_en,
  input  logic              mismatch,
  output logic [DATA_W-1:0] samp_a,
  output logic [DATA_W-1:0] samp_b,
  output logic [DATA_W-1:0] samp_c,
  output logic              judge_evt,
  output logic              arb_evt
);

  trc_state_e        state_q;
  logic [DATA_W-1:0] a_q, b_q, c_q;
  logic              vote_q;
  logic              accept_evt;
  logic              take_third;

  assign accept_evt = (state_q == ST_IDLE) && in_valid;
  assign take_third = (state_q == ST_JUDGE) && mismatch && vote_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= '0;
      vote_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            a_q     <= in_data;
            vote_q  <= vote_en;
            state_q <= state_after_accept(dly_sel);
          end
        end
        ST_HOLD:   state_q <= ST_SECOND;
        ST_SECOND: begin
          b_q     <= in_data;
          state_q <= ST_JUDGE;
        end
        ST_JUDGE: begin
          if (take_third) begin
            c_q     <= in_data;
            state_q <= ST_ARB;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_ARB:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign samp_a    = a_q;
  assign samp_b    = b_q;
  assign samp_c    = c_q;
  assign judge_evt = (state_q == ST_JUDGE);
  assign arb_evt   = (state_q == ST_ARB);

  AST_SHORT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt && !dly_sel |=> state_q == ST_SECOND); // R2
  AST_LONG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_HOLD |=> state_q == ST_SECOND); // R2
  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != ST_IDLE |=> $stable(a_q)); // R8
  AST_VOTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take_third |=> arb_evt); // R5
  AST_NO_VOTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    judge_evt && !take_third |=> state_q == ST_IDLE); // R4

endmodule

// File: rtl/trc_resolve.sv
module trc_resolve
  import trc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] samp_a,
  input  logic [DATA_W-1:0] samp_b,
  input  logic [DATA_W-1:0] samp_c,
  input  logic              judge_evt,
  input  logic              arb_evt,
  output logic              mismatch,
  output logic              disc_evt,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_corrected,
  output logic              out_flag
);

  logic [DATA_W-1:0] voted;
  logic [DATA_W-1:0] data_q;
  logic              valid_q, corr_q, flag_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_vote
    assign voted[i] = vote_bit(samp_a[i], samp_b[i], samp_c[i]);
  end

  assign mismatch = (samp_a != samp_b);
  assign disc_evt = judge_evt && mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      corr_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      corr_q  <= 1'b0;
      flag_q  <= 1'b0;
      if (judge_evt && !mismatch) begin
        data_q  <= samp_a;
        valid_q <= 1'b1;
      end else if (disc_evt) begin
        flag_q  <= 1'b1;
      end else if (arb_evt) begin
        data_q  <= voted;
        valid_q <= 1'b1;
        corr_q  <= 1'b1;
      end
    end
  end

  assign out_data      = data_q;
  assign out_valid     = valid_q;
  assign out_corrected = corr_q;
  assign out_flag      = flag_q;

  AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_flag && out_valid)); // R4
  AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_flag |=> !out_flag); // R4
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R3
  AST_CORR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_corrected |-> out_valid); // R5
  AST_AGREE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    judge_evt && !mismatch |=> out_valid && !out_corrected && out_data == $past(samp_a)); // R3

endmodule

// File: rtl/trc_event_counter.sv
module trc_event_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic bump, input logic wipe);
    if (wipe) return '0;
    if (bump && cur != CNT_MAX) return cur + 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_count(cnt_q, inc, clr);
  end

  assign count = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_MAX && !clr |=> cnt_q == CNT_MAX); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !clr |=> $stable(cnt_q)); // R6
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0); // R7

endmodule

// File: rtl/trc_guard.sv
module trc_guard
  import trc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              dly_sel,
  input  logic              vote_en,
  input  logic              cnt_clr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_corrected,
  output logic              transient_flag,
  output logic [CNT_W-1:0]  transient_count
);

  logic [DATA_W-1:0] samp_a, samp_b, samp_c;
  logic              judge_evt, arb_evt, mismatch, disc_evt;

  trc_capture #(.DATA_W(DATA_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .dly_sel   (dly_sel),
    .vote_en   (vote_en),
    .mismatch  (mismatch),
    .samp_a    (samp_a),
    .samp_b    (samp_b),
    .samp_c    (samp_c),
    .judge_evt (judge_evt),
    .arb_evt   (arb_evt)
  );

  trc_resolve #(.DATA_W(DATA_W)) u_resolve (
    .clk           (clk),
    .rst_n         (rst_n),
    .samp_a        (samp_a),
    .samp_b        (samp_b),
    .samp_c        (samp_c),
    .judge_evt     (judge_evt),
    .arb_evt       (arb_evt),
    .mismatch      (mismatch),
    .disc_evt      (disc_evt),
    .out_data      (out_data),
    .out_valid     (out_valid),
    .out_corrected (out_corrected),
    .out_flag      (transient_flag)
  );

  trc_event_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (disc_evt),
    .clr   (cnt_clr),
    .count (transient_count)
  );

  AST_FLAG_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    transient_flag && !$past(cnt_clr) |-> transient_count != '0); // R6

endmodule

// File: tb/sim_trc_guard.sv
`timescale 1ns/1ps
module sim_trc_guard;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0, dly_sel = 1'b0, vote_en = 1'b0, cnt_clr = 1'b0;
  logic [DW-1:0] out_data;
  logic          out_valid, out_corrected, transient_flag;
  logic [CW-1:0] transient_count;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trc_guard #(.DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .dly_sel(dly_sel), .vote_en(vote_en), .cnt_clr(cnt_clr),
    .out_data(out_data), .out_valid(out_valid), .out_corrected(out_corrected),
    .transient_flag(transient_flag), .transient_count(transient_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bitwise two-of-three: where the first two agree take them, else the third decides.
  function automatic logic [DW-1:0] ref_major(input logic [DW-1:0] a, b, c);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = (a[i] == b[i]) ? a[i] : c[i];
    return r;
  endfunction

  task automatic run_txn(input logic [DW-1:0] d1, d2, d3, input bit dly, vote,
                         input bit poke, glitch, clr_judge, input string tag);
    bit mis;
    @(negedge clk);
    in_valid = 1'b1; in_data = d1; dly_sel = dly; vote_en = vote;
    @(posedge clk);                         // E0
    @(negedge clk);
    in_valid = poke;
    if (poke) begin dly_sel = ~dly; vote_en = ~vote; end
    if (dly) begin
      chk("R3", "early valid", out_valid, 0);
      if (glitch) in_data = ~d1;            // R2: not a sampling edge
      @(posedge clk);                       // E0+1
      @(negedge clk);
    end
    in_data = d2;
    chk("R3", "early valid", out_valid, 0);
    @(posedge clk);                         // E0+D, second sample
    @(negedge clk);
    in_data = d3;
    if (clr_judge) cnt_clr = 1'b1;
    chk("R3", "valid before due edge", out_valid, 0);
    @(posedge clk);                         // E0+D+1
    @(negedge clk);
    cnt_clr = 1'b0; in_valid = 1'b0;
    mis = (d1 != d2);
    if (clr_judge) exp_cnt = 0;
    else if (mis && exp_cnt < CMAX) exp_cnt++;
    if (!mis) begin
      chk(tag, "valid", out_valid, 1);
      chk(tag, "data", out_data, d1);
      chk(vote ? "R9" : tag, "corrected", out_corrected, 0);
      chk(tag, "flag", transient_flag, 0);
    end else begin
      chk("R4", "flag", transient_flag, 1);
      chk("R4", "valid suppressed", out_valid, 0);
    end
    chk(clr_judge ? "R7" : "R6", "count", transient_count, exp_cnt);
    @(posedge clk);
    @(negedge clk);
    if (mis && vote) begin
      chk("R5", "voted valid", out_valid, 1);
      chk("R5", "voted data", out_data, ref_major(d1, d2, d3));
      chk("R5", "corrected", out_corrected, 1);
      chk("R5", "flag cleared", transient_flag, 0);
      @(posedge clk);
      @(negedge clk);
    end else if (mis) begin
      chk("R4", "flag one cycle", transient_flag, 0);
      chk("R4", "no late valid", out_valid, 0);
    end
    chk(poke ? "R8" : "R3", "valid one cycle", out_valid, 0);
  endtask

  initial begin
    logic [DW-1:0] a, b, c;
    int sd;
    sd = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "valid", out_valid, 0);
    chk("R1", "corrected", out_corrected, 0);
    chk("R1", "flag", transient_flag, 0);
    chk("R1", "data", out_data, 0);
    chk("R1", "count", transient_count, 0);
    rst_n = 1'b1;

    run_txn(8'h5A, 8'h5A, 8'h00, 0, 0, 0, 0, 0, "R3");
    run_txn(8'hC3, 8'hC3, 8'h00, 1, 0, 0, 1, 0, "R2");
    run_txn(8'h11, 8'h13, 8'h11, 0, 0, 0, 0, 0, "R3");
    run_txn(8'h80, 8'h00, 8'h80, 1, 0, 0, 0, 0, "R3");
    run_txn(8'h3C, 8'h3D, 8'h3C, 0, 1, 0, 0, 0, "R3");
    run_txn(8'h3C, 8'h3D, 8'h3D, 1, 1, 0, 0, 0, "R3");
    run_txn(8'hF0, 8'h0F, 8'h3C, 0, 1, 0, 0, 0, "R3");
    run_txn(8'h77, 8'h77, 8'h00, 1, 1, 0, 1, 0, "R9");
    run_txn(8'h42, 8'h42, 8'h00, 0, 0, 1, 0, 0, "R8");
    run_txn(8'h42, 8'h40, 8'h00, 1, 0, 1, 0, 0, "R8");

    // R7: explicit clear
    @(negedge clk); cnt_clr = 1'b1;
    @(posedge clk); @(negedge clk); cnt_clr = 1'b0; exp_cnt = 0;
    chk("R7", "cleared count", transient_count, 0);

    // R6: saturation
    for (int k = 0; k < CMAX + 5; k++)
      run_txn(8'(k), 8'(k) ^ 8'h01, 8'h00, k[0], 0, 0, 0, 0, "R6");
    chk("R6", "saturated count", transient_count, CMAX);

    // R7: clear coinciding with a counted mismatch
    run_txn(8'h99, 8'h98, 8'h99, 0, 0, 0, 0, 1, "R7");

    for (int k = 0; k < 150; k++) begin
      a = 8'($urandom);
      b = ($urandom % 3 == 0) ? a ^ 8'(1 << ($urandom % DW)) : a;
      c = ($urandom % 2 == 0) ? a : 8'($urandom);
      run_txn(a, b, c, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              ($urandom % 16 == 0), "R3");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule